// File: doc/BRIEF.md
# USB Full/Low-Speed Tracker

This block watches a USB segment that carries both full-speed and low-speed traffic and tells the receive path which bit rate to decode at. An upstream decoder hands it one pulse per recognised packet, tagged with a packet kind, plus a pulse at every end of packet. From that stream the block follows each transaction that a preamble opens. It holds low speed for the low-speed portions and drops back to full speed when the exchange completes, when an unexpected packet arrives, or when the line stays quiet for too long.

The OUT/SETUP path and the IN path are tracked separately. After an OUT or SETUP token the host returns to full speed and needs a second preamble before its low-speed data packet. After an IN token the device answers at low speed directly. A strap input pins the block to low speed on a segment that carries only low-speed traffic. The time-out windows count low-speed bit times, and a bit time is a parameterised number of clock cycles.

Top module: `usb_speed_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, state_o is 0 (full-speed idle) and low_speed_o is 0.
- R2: In idle (0), a packet of kind 0 (preamble) moves the block to state 1 (low-speed token wait) on the next clock edge. Any other packet kind leaves it in idle.
- R3: In state 1, a packet of kind 1 (SETUP) or kind 2 (OUT) moves the block to state 2 (full-speed wait for host data) with low_speed_o at 0.
- R4: In state 2, a preamble moves to state 3 (low-speed host data wait). In state 3, kind 4 (DATA) moves to state 4 (handshake wait) and kind 5 (handshake) returns to idle. In state 4, a handshake returns to idle.
- R5: In state 1, a packet of kind 3 (IN) moves to state 5 (device data wait). A DATA packet in state 5 returns to idle.
- R6: State 5 returns to idle on the edge after 18 × CYC_PER_BIT cycles with no packet and no end of packet. It is still in state 5 one cycle earlier.
- R7: States 1, 3 and 4 return to idle on the edge after 16 × CYC_PER_BIT cycles with no packet and no end of packet. They are still in the same state one cycle earlier.
- R8: An end-of-packet pulse during a low-speed wait restarts the time-out window from that edge.
- R9: While the strap ls_only_i is high, the block enters state 6 (forced low speed) on the next edge and ignores every packet. When the strap falls, the block returns to idle on the next edge.
- R10: A packet kind not listed for the current state returns the block to idle (for example kind 3 in state 2, kind 3 in state 5, and kinds 4 or 7 in states 1 or 4).
- R11: low_speed_o is 1 exactly in states 1, 3, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CYC_PER_BIT cycles per low-speed bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_only_i | input | 1 | Strap: segment carries low-speed traffic only |
| pkt_valid_i | input | 1 | One-cycle pulse: a packet was decoded |
| pkt_kind_i | input | 3 | Packet kind: 0 preamble, 1 SETUP, 2 OUT, 3 IN, 4 DATA, 5 handshake, 6/7 other |
| eop_i | input | 1 | One-cycle pulse at each end of packet |
| low_speed_o | output | 1 | 1 = decode at low speed |
| state_o | output | 3 | Current tracking state (codes as in the requirements) |

## Verification
The time-out boundaries are the hardest cases to reach from the ports. The line has to stay silent for exactly the window length, and the check must land on the one edge where the block gives up. The stimulus opens a low-speed wait with a single packet pulse, counts clock edges from that edge, and samples one edge before and one edge after the limit. For the restart case it inserts an end-of-packet pulse part way through the window and counts again from that pulse. Strap toggling and unexpected packet kinds are mixed into a table-driven transaction walk.

// File: rtl/usb_spd_pkg.sv
package usb_spd_pkg;

  typedef enum logic [2:0] {
    ST_FS_IDLE   = 3'd0,
    ST_LS_TOKEN  = 3'd1,
    ST_FS_HWAIT  = 3'd2,
    ST_LS_HDATA  = 3'd3,
    ST_LS_HSHK   = 3'd4,
    ST_LS_INDATA = 3'd5,
    ST_LS_ONLY   = 3'd6
  } spd_state_e;

  localparam logic [2:0] PK_PRE   = 3'd0;
  localparam logic [2:0] PK_SETUP = 3'd1;
  localparam logic [2:0] PK_OUT   = 3'd2;
  localparam logic [2:0] PK_IN    = 3'd3;
  localparam logic [2:0] PK_DATA  = 3'd4;
  localparam logic [2:0] PK_HSK   = 3'd5;

  // cycles in a window of the given number of low-speed bit times
  function automatic int unsigned bit_window(int unsigned bits, int unsigned cyc);
    return bits * cyc;
  endfunction

  function automatic logic state_is_low(spd_state_e s);
    return s inside {ST_LS_TOKEN, ST_LS_HDATA, ST_LS_HSHK, ST_LS_INDATA, ST_LS_ONLY};
  endfunction

  // states in which the time-out window runs
  function automatic logic state_waits(spd_state_e s);
    return s inside {ST_LS_TOKEN, ST_LS_HDATA, ST_LS_HSHK, ST_LS_INDATA};
  endfunction

endpackage

// File: rtl/spd_timer.sv
module spd_timer
  import usb_spd_pkg::*;
#(
  parameter int unsigned CYC_PER_BIT = 32,
  parameter int unsigned WAIT_BITS   = 16,
  parameter int unsigned IN_BITS     = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_win,
  input  logic restart,
  output logic expired
);
  localparam int unsigned WAIT_LIM = bit_window(WAIT_BITS, CYC_PER_BIT);
  localparam int unsigned IN_LIM   = bit_window(IN_BITS, CYC_PER_BIT);
  localparam int unsigned MAX_LIM  = (WAIT_LIM > IN_LIM) ? WAIT_LIM : IN_LIM;
  localparam int unsigned CW       = $clog2(MAX_LIM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = long_win ? CW'(IN_LIM) : CW'(WAIT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign expired = run && !restart && (cnt == limit);

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));

endmodule

// File: rtl/spd_fsm.sv
module spd_fsm
  import usb_spd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ls_only,
  input  logic       pkt_valid,
  input  logic [2:0] pkt_kind,
  input  logic       expired,
  output logic [2:0] state,
  output logic       strap_chg
);
  spd_state_e cur, nxt;
  logic       strap_q;

  assign strap_chg = (ls_only != strap_q);

  always_comb begin
    nxt = cur;
    if (strap_chg) begin
      nxt = ls_only ? ST_LS_ONLY : ST_FS_IDLE;
    end else begin
      case (cur)
        ST_FS_IDLE:
          if (pkt_valid && pkt_kind == PK_PRE) nxt = ST_LS_TOKEN;
        ST_LS_TOKEN:
          if (pkt_valid) begin
            if (pkt_kind == PK_SETUP || pkt_kind == PK_OUT) nxt = ST_FS_HWAIT;
            else if (pkt_kind == PK_IN)                     nxt = ST_LS_INDATA;
            else                                            nxt = ST_FS_IDLE;
          end else if (expired) nxt = ST_FS_IDLE;
        ST_FS_HWAIT:
          if (pkt_valid) nxt = (pkt_kind == PK_PRE) ? ST_LS_HDATA : ST_FS_IDLE;
        ST_LS_HDATA:
          if (pkt_valid) nxt = (pkt_kind == PK_DATA) ? ST_LS_HSHK : ST_FS_IDLE;
          else if (expired) nxt = ST_FS_IDLE;
        ST_LS_HSHK, ST_LS_INDATA:
          if (pkt_valid || expired) nxt = ST_FS_IDLE;
        ST_LS_ONLY:
          nxt = ST_LS_ONLY;
        default:
          nxt = ST_FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= ST_FS_IDLE;
      strap_q <= 1'b0;
    end else begin
      cur     <= nxt;
      strap_q <= ls_only;
    end
  end

  assign state = cur;

  // R2
  pre_enters_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == ST_FS_IDLE && pkt_valid && pkt_kind == PK_PRE && !ls_only && !strap_q)
      |=> (cur == ST_LS_TOKEN));

  // R10
  unexpected_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ls_only && !strap_q && pkt_valid && (cur == ST_LS_HSHK || cur == ST_LS_INDATA))
      |=> (cur == ST_FS_IDLE));

  // R9
  strap_holds_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_only |=> (cur == ST_LS_ONLY));

  // R7
  expiry_returns_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !pkt_valid && !strap_chg) |=> (cur == ST_FS_IDLE));

endmodule

// File: rtl/usb_speed_tracker.sv
module usb_speed_tracker
  import usb_spd_pkg::*;
#(
  parameter int unsigned CYC_PER_BIT = 32,
  parameter int unsigned WAIT_BITS   = 16,
  parameter int unsigned IN_BITS     = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ls_only_i,
  input  logic       pkt_valid_i,
  input  logic [2:0] pkt_kind_i,
  input  logic       eop_i,
  output logic       low_speed_o,
  output logic [2:0] state_o
);
  logic [2:0] fsm_state;
  logic       strap_chg;
  logic       win_run;
  logic       win_long;
  logic       win_restart;
  logic       win_expired;

  assign win_run     = state_waits(spd_state_e'(fsm_state));
  assign win_long    = (fsm_state == ST_LS_INDATA);
  assign win_restart = eop_i | pkt_valid_i | strap_chg;

  spd_timer #(
    .CYC_PER_BIT(CYC_PER_BIT),
    .WAIT_BITS  (WAIT_BITS),
    .IN_BITS    (IN_BITS)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (win_run),
    .long_win(win_long),
    .restart (win_restart),
    .expired (win_expired)
  );

  spd_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ls_only  (ls_only_i),
    .pkt_valid(pkt_valid_i),
    .pkt_kind (pkt_kind_i),
    .expired  (win_expired),
    .state    (fsm_state),
    .strap_chg(strap_chg)
  );

  assign low_speed_o = state_is_low(spd_state_e'(fsm_state));
  assign state_o     = fsm_state;

  // R3
  out_setup_to_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_LS_TOKEN && pkt_valid_i && !ls_only_i && !strap_chg &&
     (pkt_kind_i == PK_SETUP || pkt_kind_i == PK_OUT)) |=> !low_speed_o);

endmodule

// File: tb/test_usb_speed_tracker.sv
module test_usb_speed_tracker;
  localparam int CPB    = 32;
  localparam int WLIM   = 16 * CPB;
  localparam int ILIM   = 18 * CPB;
  localparam int NV     = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ls_only = 1'b0;
  logic       pkt_valid = 1'b0;
  logic [2:0] pkt_kind = 3'd0;
  logic       eop = 1'b0;
  logic       low_speed;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_speed_tracker i_usb_speed_tracker (
    .clk(clk), .rst_n(rst_n), .ls_only_i(ls_only), .pkt_valid_i(pkt_valid),
    .pkt_kind_i(pkt_kind), .eop_i(eop), .low_speed_o(low_speed), .state_o(state)
  );

  // {strap, valid, kind[2:0], eop, exp_state[2:0], exp_low}
  localparam logic [9:0] VEC [NV] = '{
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd1,1'b0,3'd2,1'b0},
    {1'b0,1'b0,3'd0,1'b1,3'd2,1'b0}, {1'b0,1'b1,3'd0,1'b0,3'd3,1'b1},
    {1'b0,1'b1,3'd4,1'b0,3'd4,1'b1}, {1'b0,1'b1,3'd5,1'b0,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd2,1'b0,3'd2,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd3,1'b1}, {1'b0,1'b1,3'd5,1'b0,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd3,1'b0,3'd5,1'b1},
    {1'b0,1'b1,3'd4,1'b0,3'd0,1'b0}, {1'b0,1'b1,3'd4,1'b0,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd7,1'b0,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd2,1'b0,3'd2,1'b0},
    {1'b0,1'b1,3'd3,1'b0,3'd0,1'b0}, {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1},
    {1'b0,1'b1,3'd3,1'b0,3'd5,1'b1}, {1'b0,1'b1,3'd3,1'b0,3'd0,1'b0},
    {1'b1,1'b0,3'd0,1'b0,3'd6,1'b1}, {1'b1,1'b1,3'd0,1'b0,3'd6,1'b1},
    {1'b1,1'b1,3'd5,1'b0,3'd6,1'b1}, {1'b0,1'b0,3'd0,1'b0,3'd0,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd1,1'b1}, {1'b0,1'b1,3'd1,1'b0,3'd2,1'b0},
    {1'b0,1'b1,3'd0,1'b0,3'd3,1'b1}, {1'b0,1'b1,3'd4,1'b0,3'd4,1'b1},
    {1'b0,1'b1,3'd4,1'b0,3'd0,1'b0}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(logic s, logic v, logic [2:0] k, logic e);
    @(negedge clk);
    ls_only = s; pkt_valid = v; pkt_kind = k; eop = e;
    @(posedge clk);
    #1;
    pkt_valid = 1'b0; eop = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 state in reset", state, 0);
    check("R1 low_speed in reset", low_speed, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 state after reset", state, 0);

    // transaction walk: R2 R3 R4 R5 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][9], VEC[i][8], VEC[i][7:5], VEC[i][4]);
      check($sformatf("R2/R3/R4/R5/R9/R10 row %0d state", i), state, int'(VEC[i][3:1]));
      check($sformatf("R11 row %0d low_speed", i), low_speed, int'(VEC[i][0]));
    end

    // R7: token wait time-out
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    repeat (WLIM) @(posedge clk);
    #1 check("R7 token wait just before limit", state, 1);
    @(posedge clk); #1;
    check("R7 token wait after limit", state, 0);
    check("R7 low_speed after limit", low_speed, 0);

    // R6: IN data time-out
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    pulse(1'b0, 1'b1, 3'd3, 1'b0);
    repeat (ILIM) @(posedge clk);
    #1 check("R6 IN wait just before limit", state, 5);
    @(posedge clk); #1;
    check("R6 IN wait after limit", state, 0);

    // R8: end of packet restarts the window
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    repeat (400) @(posedge clk);
    pulse(1'b0, 1'b0, 3'd0, 1'b1);
    repeat (WLIM) @(posedge clk);
    #1 check("R8 still waiting after restart", state, 1);
    @(posedge clk); #1;
    check("R8 expiry counted from eop", state, 0);

    // R7: handshake wait time-out
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    pulse(1'b0, 1'b1, 3'd2, 1'b0);
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    pulse(1'b0, 1'b1, 3'd4, 1'b0);
    repeat (WLIM) @(posedge clk);
    #1 check("R7 handshake wait before limit", state, 4);
    @(posedge clk); #1;
    check("R7 handshake wait after limit", state, 0);

    // R1: reset in the middle of a low-speed wait
    pulse(1'b0, 1'b1, 3'd0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 reset mid-transaction", state, 0);
    check("R1 reset mid-transaction low_speed", low_speed, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: strap after reset takes effect on the next edge
    pulse(1'b1, 1'b0, 3'd0, 1'b0);
    check("R9 strap forces low speed", low_speed, 1);
    repeat (WLIM + 50) @(posedge clk);
    #1 check("R9 forced low speed has no time-out", state, 6);
    pulse(1'b0, 1'b0, 3'd0, 1'b0);
    check("R9 strap release to idle", state, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule